// File: doc/BRIEF.md
# Pause and Backpressure Flow Controller

This block watches the buffer-queue occupancy of every switch port and turns it into flow-control actions. All ports share one pair of thresholds: a high mark that signals congestion and a low mark that signals relief. The hysteresis between the two marks stops a queue that sits near one level from toggling the link partner's state.

On a full-duplex port with pause signalling enabled, the block asks the MAC transmitter for a PAUSE frame with the maximum pause time when occupancy reaches the high mark. When occupancy later drains to the low mark, it asks for a PAUSE frame with a zero pause time. Each request is held until the MAC acknowledges it.

On a half-duplex port with backpressure enabled, the block asks the receive side to jam the line while the queue is at or above the high mark and carrier is sensed. Without backpressure, an incoming packet is marked for dropping when no free buffer is left. Frame assembly and the MAC are outside this block. Typical thresholds are 0x74/0x30 for a 2 MB buffer and 0x2E/0x18 for a 1 MB buffer.

Top module: `pause_bp_ctrl`

## Requirements
- R1: After reset, pause_req_o, jam_o and drop_o are all zero.
- R2: When a port is in full duplex (full_dup_i bit = 1), fc_en_i = 1, no pause exchange is under way and occupancy is at or above hi_th_i, the port's pause_req_o bit rises one clock later. Its 16-bit slice of pause_time_o (bits p*16+15 down to p*16) is then 0xFFFF. Occupancy one below hi_th_i raises no request.
- R3: A pause request and its pause time stay constant until the clock edge at which the port's pause_ack_i is high. The request is low in the cycle after that edge.
- R4: After the maximum-time PAUSE is acknowledged, no further request is raised while occupancy stays above lo_th_i, even if it moves back above hi_th_i.
- R5: Once the maximum-time PAUSE has been acknowledged and occupancy is at or below lo_th_i, a request with pause time 0x0000 is raised one clock later. Occupancy one above lo_th_i raises no request. A new maximum-time request is possible only after the zero-time request is acknowledged.
- R6: No pause request is raised while the port is in half duplex or fc_en_i = 0. A pending request is withdrawn when either of these conditions appears.
- R7: jam_o for a port is 1 one clock after a cycle in which the port is in half duplex, bp_en_i = 1, occupancy is at or above hi_th_i and crs_i is high. In every other case it is 0.
- R8: drop_o for a port is 1 one clock after a cycle in which crs_i is high, free_avail_i = 0 and backpressure is not in effect for that port (bp_en_i = 0 or full duplex). In every other case it is 0. jam_o and drop_o are never both high.
- R9: Each port's occupancy, duplex, carrier and acknowledge inputs affect only that port's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| occ_i | input | NUM_PORTS*CNT_W | Queue occupancy per port, port p at bits p*CNT_W upward |
| hi_th_i | input | CNT_W | Congestion threshold (maximum-time PAUSE, jam) |
| lo_th_i | input | CNT_W | Relief threshold (zero-time PAUSE) |
| full_dup_i | input | NUM_PORTS | 1 = port in full duplex, 0 = half duplex |
| fc_en_i | input | 1 | Enable for PAUSE signalling in full duplex |
| bp_en_i | input | 1 | Enable for jamming in half duplex |
| crs_i | input | NUM_PORTS | Receive carrier sense per port |
| free_avail_i | input | 1 | 1 = at least one free buffer remains |
| pause_ack_i | input | NUM_PORTS | MAC accepts the pending PAUSE request |
| pause_req_o | output | NUM_PORTS | PAUSE frame request per port |
| pause_time_o | output | NUM_PORTS*PT_W | Pause time for the request, port p at bits p*PT_W upward |
| jam_o | output | NUM_PORTS | Jam request on the receive side |
| drop_o | output | NUM_PORTS | Drop the incoming packet |

## Verification
The assertions check on every cycle that a pending PAUSE request holds with a steady pause time until it is acknowledged or its mode is left, and that no request appears in half duplex. They also check that the pause time is only ever all-ones or zero, that each jam or drop pulse has the cause the requirements name in the previous cycle, and that jam and drop never coincide. The bench scenarios show what a single-cycle property cannot: one request per threshold crossing, the exact boundary values on both thresholds, withdrawal on a mode change, the switch to the second threshold set, and ports acting independently while their requests overlap.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  typedef enum logic [1:0] {
    PS_IDLE     = 2'd0,  // no pause exchange under way
    PS_REQ_STOP = 2'd1,  // maximum-time pause requested
    PS_HOLD     = 2'd2,  // maximum-time pause sent, waiting for drain
    PS_REQ_GO   = 2'd3   // zero-time pause requested
  } pause_st_e;
endpackage

// File: rtl/pbc_level_det.sv
module pbc_level_det #(
  parameter int CNT_W = 11
) (
  input  logic [CNT_W-1:0] occ_i,
  input  logic [CNT_W-1:0] hi_th_i,
  input  logic [CNT_W-1:0] lo_th_i,
  output logic             at_hi_o,
  output logic             at_lo_o
);
  always_comb begin
    at_hi_o = (occ_i >= hi_th_i);
    at_lo_o = (occ_i <= lo_th_i);
  end
endmodule

// File: rtl/pbc_pause_fsm.sv
module pbc_pause_fsm #(
  parameter int PT_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fd_en_i,   // full duplex and pause signalling enabled
  input  logic            at_hi_i,
  input  logic            at_lo_i,
  input  logic            ack_i,
  output logic            req_o,
  output logic [PT_W-1:0] time_o
);
  import pbc_pkg::*;

  pause_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!fd_en_i) begin
      st_d = PS_IDLE;
    end else begin
      unique case (st_q)
        PS_IDLE:     if (at_hi_i) st_d = PS_REQ_STOP;
        PS_REQ_STOP: if (ack_i)   st_d = PS_HOLD;
        PS_HOLD:     if (at_lo_i) st_d = PS_REQ_GO;
        PS_REQ_GO:   if (ack_i)   st_d = PS_IDLE;
        default:                  st_d = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= PS_IDLE;
    else         st_q <= st_d;
  end

  // gate with mode so a withdrawn request never shows for a cycle
  assign req_o  = fd_en_i && ((st_q == PS_REQ_STOP) || (st_q == PS_REQ_GO));
  assign time_o = (st_q == PS_REQ_STOP) ? {PT_W{1'b1}} : {PT_W{1'b0}};
endmodule

// File: rtl/pbc_half_ctrl.sv
module pbc_half_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic half_i,
  input  logic bp_en_i,
  input  logic at_hi_i,
  input  logic crs_i,
  input  logic free_avail_i,
  output logic jam_o,
  output logic drop_o
);
  logic bp_act;
  logic jam_d, drop_d;

  always_comb begin
    bp_act = half_i && bp_en_i;
    jam_d  = bp_act && at_hi_i && crs_i;
    drop_d = !bp_act && crs_i && !free_avail_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      jam_o  <= 1'b0;
      drop_o <= 1'b0;
    end else begin
      jam_o  <= jam_d;
      drop_o <= drop_d;
    end
  end
endmodule

// File: rtl/pause_bp_ctrl.sv
module pause_bp_ctrl #(
  parameter int NUM_PORTS = 5,
  parameter int CNT_W     = 11,
  parameter int PT_W      = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PORTS*CNT_W-1:0] occ_i,
  input  logic [CNT_W-1:0]          hi_th_i,
  input  logic [CNT_W-1:0]          lo_th_i,
  input  logic [NUM_PORTS-1:0]      full_dup_i,
  input  logic                      fc_en_i,
  input  logic                      bp_en_i,
  input  logic [NUM_PORTS-1:0]      crs_i,
  input  logic                      free_avail_i,
  input  logic [NUM_PORTS-1:0]      pause_ack_i,
  output logic [NUM_PORTS-1:0]      pause_req_o,
  output logic [NUM_PORTS*PT_W-1:0] pause_time_o,
  output logic [NUM_PORTS-1:0]      jam_o,
  output logic [NUM_PORTS-1:0]      drop_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic at_hi, at_lo;
    logic fd_en;

    assign fd_en = full_dup_i[p] && fc_en_i;

    pbc_level_det #(.CNT_W(CNT_W)) level_i (
      .occ_i   (occ_i[p*CNT_W +: CNT_W]),
      .hi_th_i (hi_th_i),
      .lo_th_i (lo_th_i),
      .at_hi_o (at_hi),
      .at_lo_o (at_lo)
    );

    pbc_pause_fsm #(.PT_W(PT_W)) pause_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fd_en_i (fd_en),
      .at_hi_i (at_hi),
      .at_lo_i (at_lo),
      .ack_i   (pause_ack_i[p]),
      .req_o   (pause_req_o[p]),
      .time_o  (pause_time_o[p*PT_W +: PT_W])
    );

    pbc_half_ctrl half_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .half_i       (!full_dup_i[p]),
      .bp_en_i      (bp_en_i),
      .at_hi_i      (at_hi),
      .crs_i        (crs_i[p]),
      .free_avail_i (free_avail_i),
      .jam_o        (jam_o[p]),
      .drop_o       (drop_o[p])
    );
  end
endmodule

// File: rtl/pbc_chk.sv
module pbc_chk #(
  parameter int NUM_PORTS = 5,
  parameter int CNT_W     = 11,
  parameter int PT_W      = 16
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_PORTS*CNT_W-1:0] occ_i,
  input logic [CNT_W-1:0]          hi_th_i,
  input logic [CNT_W-1:0]          lo_th_i,
  input logic [NUM_PORTS-1:0]      full_dup_i,
  input logic                      fc_en_i,
  input logic                      bp_en_i,
  input logic [NUM_PORTS-1:0]      crs_i,
  input logic                      free_avail_i,
  input logic [NUM_PORTS-1:0]      pause_ack_i,
  input logic [NUM_PORTS-1:0]      pause_req_o,
  input logic [NUM_PORTS*PT_W-1:0] pause_time_o,
  input logic [NUM_PORTS-1:0]      jam_o,
  input logic [NUM_PORTS-1:0]      drop_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    // R3
    req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pause_req_o[p] && !pause_ack_i[p])
      |=> (pause_req_o[p] || !(full_dup_i[p] && fc_en_i)));

    // R3
    time_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pause_req_o[p] && !pause_ack_i[p])
      |=> (!pause_req_o[p] || $stable(pause_time_o[p*PT_W +: PT_W])));

    // R6
    no_half_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!full_dup_i[p] || !fc_en_i) |-> !pause_req_o[p]);

    // R2
    time_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pause_req_o[p] |-> ((pause_time_o[p*PT_W +: PT_W] == {PT_W{1'b1}}) ||
                          (pause_time_o[p*PT_W +: PT_W] == {PT_W{1'b0}})));

    // R7
    jam_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      jam_o[p] |-> $past(!full_dup_i[p] && bp_en_i && crs_i[p] &&
                         (occ_i[p*CNT_W +: CNT_W] >= hi_th_i)));

    // R8
    drop_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drop_o[p] |-> $past(crs_i[p] && !free_avail_i));

    // R8
    jam_drop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(jam_o[p] && drop_o[p]));
  end
endmodule

bind pause_bp_ctrl pbc_chk #(
  .NUM_PORTS (NUM_PORTS),
  .CNT_W     (CNT_W),
  .PT_W      (PT_W)
) chk_i (.*);

// File: tb/pause_bp_ctrl_tb_top.sv
`timescale 1ns/1ps
module pause_bp_ctrl_tb_top;
  localparam int NP = 5;
  localparam int CW = 11;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [CW-1:0]    occ [NP];
  logic [NP*CW-1:0] occ_flat;
  logic [CW-1:0]    hi_th, lo_th;
  logic [NP-1:0]    full_dup, crs, ack;
  logic             fc_en, bp_en, free_avail;
  logic [NP-1:0]    pause_req, jam, drop;
  logic [NP*TW-1:0] pause_time;

  always_comb
    for (int p = 0; p < NP; p++) occ_flat[p*CW +: CW] = occ[p];

  pause_bp_ctrl #(.NUM_PORTS(NP), .CNT_W(CW), .PT_W(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .occ_i(occ_flat), .hi_th_i(hi_th),
    .lo_th_i(lo_th), .full_dup_i(full_dup), .fc_en_i(fc_en), .bp_en_i(bp_en),
    .crs_i(crs), .free_avail_i(free_avail), .pause_ack_i(ack),
    .pause_req_o(pause_req), .pause_time_o(pause_time), .jam_o(jam),
    .drop_o(drop)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    int          port;
    logic [15:0] tm;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic check(string tag, int act, int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_pause(int p, logic [15:0] tm, string tag);
    exp_t e;
    e.port = p; e.tm = tm; e.tag = tag;
    exp_q.push_back(e);
  endtask

  function automatic int ptime(int p);
    return int'(pause_time[p*TW +: TW]);
  endfunction

  task automatic ack_port(int p, string tag);
    step();
    ack[p] = 1'b1;
    step();
    ack[p] = 1'b0;
    check({tag, " request cleared after ack"}, int'(pause_req[p]), 0);
  endtask

  // monitor: pops the expected item at each handshake
  always @(negedge clk) begin
    exp_t e;
    #1;
    for (int p = 0; p < NP; p++) begin
      if (rst_n && pause_req[p] && ack[p]) begin
        if (exp_q.size() == 0) begin
          check("R3 unexpected handshake port", p, -1);
        end else begin
          e = exp_q.pop_front();
          check({e.tag, " port"}, p, e.port);
          check({e.tag, " pause time"}, ptime(p), int'(e.tm));
        end
      end
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) occ[p] = '0;
    hi_th = 11'h074; lo_th = 11'h030;
    full_dup = '1; crs = '0; ack = '0;
    fc_en = 1'b1; bp_en = 1'b1; free_avail = 1'b1;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1
    check("R1 pause_req after reset", int'(pause_req), 0);
    check("R1 jam after reset", int'(jam), 0);
    check("R1 drop after reset", int'(drop), 0);

    // R2 boundary below and at the high mark
    occ[0] = 11'h073; step(); step();
    check("R2 no request one below hi", int'(pause_req[0]), 0);
    occ[0] = 11'h074; expect_pause(0, 16'hFFFF, "R2 max pause");
    step();
    check("R2 request at hi", int'(pause_req[0]), 1);
    check("R2 time at hi", ptime(0), 16'hFFFF);
    // R3 hold without ack
    repeat (3) step();
    check("R3 request held", int'(pause_req[0]), 1);
    check("R3 time held", ptime(0), 16'hFFFF);
    ack_port(0, "R3");

    // R4 one request per crossing
    occ[0] = 11'h080; step(); step();
    check("R4 no repeat above hi", int'(pause_req[0]), 0);
    occ[0] = 11'h050; step();
    occ[0] = 11'h090; step(); step();
    check("R4 no repeat after re-cross", int'(pause_req[0]), 0);

    // R5 boundary above and at the low mark
    occ[0] = 11'h031; step(); step();
    check("R5 no request one above lo", int'(pause_req[0]), 0);
    occ[0] = 11'h030; expect_pause(0, 16'h0000, "R5 zero pause");
    step();
    check("R5 request at lo", int'(pause_req[0]), 1);
    check("R5 zero time", ptime(0), 0);
    ack_port(0, "R5");
    step();
    check("R5 no repeat at lo", int'(pause_req[0]), 0);
    occ[0] = 11'h074; expect_pause(0, 16'hFFFF, "R5 second max pause");
    step();
    check("R5 new max after zero acked", int'(pause_req[0]), 1);
    ack_port(0, "R5");
    occ[0] = 11'h000; expect_pause(0, 16'h0000, "R5 second zero pause");
    step();
    ack_port(0, "R5");

    // R6 half duplex, disabled, and withdrawal
    full_dup[1] = 1'b0; occ[1] = 11'h080; step(); step();
    check("R6 no pause in half duplex", int'(pause_req[1]), 0);
    occ[3] = 11'h080; step();
    check("R6 port3 request before withdrawal", int'(pause_req[3]), 1);
    full_dup[3] = 1'b0; step();
    check("R6 request withdrawn in half duplex", int'(pause_req[3]), 0);
    occ[3] = '0; step(); full_dup[3] = 1'b1; step();
    fc_en = 1'b0; occ[2] = 11'h080; step(); step();
    check("R6 no pause with fc disabled", int'(pause_req[2]), 0);
    occ[2] = '0;

    // R7 jam on half-duplex port1 (occ 0x80)
    crs[1] = 1'b1; step();
    check("R7 jam raised", int'(jam[1]), 1);
    crs[1] = 1'b0; step();
    check("R7 jam off without carrier", int'(jam[1]), 0);
    occ[1] = 11'h073; crs[1] = 1'b1; step();
    check("R7 jam off below hi", int'(jam[1]), 0);
    occ[1] = 11'h074; bp_en = 1'b0; step();
    check("R7 jam off with bp disabled", int'(jam[1]), 0);
    bp_en = 1'b1; occ[4] = 11'h080; crs[4] = 1'b1; step();
    check("R7 no jam in full duplex", int'(jam[4]), 0);
    check("R7 half port jams", int'(jam[1]), 1);

    // R8 drop
    occ[4] = '0; crs[4] = 1'b0; free_avail = 1'b0; crs[2] = 1'b1; step();
    check("R8 drop full duplex no buffer", int'(drop[2]), 1);
    check("R8 no drop under backpressure", int'(drop[1]), 0);
    bp_en = 1'b0; step();
    check("R8 drop with bp disabled", int'(drop[1]), 1);
    check("R8 no jam with drop", int'(jam[1]), 0);
    free_avail = 1'b1; step();
    check("R8 drop cleared with free buffer", int'(drop), 0);

    // R9 independence, 1 MB thresholds
    crs = '0; bp_en = 1'b1;
    for (int p = 0; p < NP; p++) occ[p] = '0;
    full_dup = '1; hi_th = 11'h02E; lo_th = 11'h018; step();
    fc_en = 1'b1;
    occ[2] = 11'h02E; occ[4] = 11'h010; expect_pause(2, 16'hFFFF, "R9 port2 max");
    step();
    check("R9 only port2 requests", int'(pause_req), 5'b00100);
    ack_port(2, "R9");
    occ[2] = 11'h018; occ[4] = 11'h02E;
    expect_pause(2, 16'h0000, "R9 port2 zero");
    expect_pause(4, 16'hFFFF, "R9 port4 max");
    step();
    check("R9 both ports request", int'(pause_req), 5'b10100);
    check("R9 port4 time", ptime(4), 16'hFFFF);
    ack_port(2, "R9");
    check("R9 port4 still pending", int'(pause_req), 5'b10000);
    ack_port(4, "R9");
    step();
    check("R3 all expected handshakes seen", exp_q.size(), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule